// File: doc/BRIEF.md
# Byte-Writable Asynchronous Static RAM Sequencer

This block is a clocked controller for an external asynchronous static RAM of 8192 words of 16 bits. The RAM has one shared data bus, an active-low select, an active-low output enable and one active-low write strobe per byte. On the host side there is a request/acknowledge port. The host holds a request until it sees a single-cycle acknowledge. The controller turns each request into a timed sequence of pin changes. Each phase (address setup, strobe low, hold after the strobe, read access) lasts a whole number of clock cycles, and a separate parameter sets each count. The defaults suit a 100 MHz clock.

The RAM pins come out as separate signals: an output data word, an output-drive enable and an input data word. The pad-level tri-state buffer sits outside this block. Every pin is registered, so the strobes and enables change only on clock edges and never glitch. The controller drives the bus only while output enable is high. When an access changes direction from the one before it, one extra idle cycle is inserted, with the select high and the bus released. Between transactions the select goes high, so the RAM rests in standby.

Top module: `sram_seq_ctrl`

## Requirements
- R1: After reset and in every cycle without an access, `mem_cs_n`=1, `mem_oe_n`=1, `mem_wr_n`=2'b11, `mem_dq_oe`=0 and `ack`=0.
- R2: A write has three phases, in this order: SETUP_CYC cycles with select low and strobes high; then STROBE_CYC cycles with the chosen strobes low; then HOLD_CYC cycles with strobes high and select low. Address and write data stay driven and unchanged through all three phases.
- R3: Mask bit 0 lowers `mem_wr_n[0]`, which covers data bits 7:0. Mask bit 1 lowers `mem_wr_n[1]`, which covers data bits 15:8. A byte whose mask bit is 0 is left unchanged in the RAM, and a mask of 2'b00 writes nothing.
- R4: A read holds select and output enable low, with both strobes high, for ACC_CYC cycles. `mem_dq_i` is sampled at the end of the last of these cycles and appears on `rdata` in the acknowledge cycle.
- R5: `mem_dq_oe` is 1 only while `mem_oe_n` is 1 and the select is low. A strobe is never low while output enable is low.
- R6: When a read follows a write, or a write follows a read, exactly one extra cycle with select high and the bus released is added before the access begins. The first access after reset and accesses in the same direction get no extra cycle.
- R7: `ack` is high for exactly one cycle per request. It rises in the same cycle in which the select returns high. Counting from the edge that accepts a request, it is high after SETUP_CYC+STROBE_CYC+HOLD_CYC edges for a write and after ACC_CYC edges for a read, plus one edge when R6 applies.
- R8: A request is accepted only when the controller is idle and not in its acknowledge cycle. A `req_valid` still held high during the acknowledge cycle starts no second access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present; held until `ack` |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 13 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Byte select for writes (bit 0 = low byte) |
| ack | output | 1 | Single-cycle completion pulse |
| rdata | output | 16 | Read result, valid with `ack` |
| mem_addr | output | 13 | RAM address pins |
| mem_cs_n | output | 1 | RAM select, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_wr_n | output | 2 | Per-byte write strobes, active low |
| mem_dq_o | output | 16 | Data the controller drives onto the bus |
| mem_dq_oe | output | 1 | Bus drive enable toward the pad buffer |
| mem_dq_i | input | 16 | Data the RAM drives onto the bus |

## Verification
The assertions assume the host protocol holds: the host keeps `req_valid` and all request fields steady from the moment it raises them until it sees `ack`, and then drops `req_valid`. The turnaround checks look two cycles back, so they also assume reset lasts at least two cycles. The bench drives every request through one task that applies exactly this discipline, and it holds reset for five cycles. One directed case deliberately keeps `req_valid` high through the acknowledge cycle to exercise R8. Random operations use a small pool of addresses that includes both ends of the range, so that reads often return data that earlier partial writes changed.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_TURN   = 3'd1,
        PH_SETUP  = 3'd2,
        PH_STROBE = 3'd3,
        PH_HOLD   = 3'd4,
        PH_ACCESS = 3'd5
    } phase_e;

    function automatic int max4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/sram_lane_gate.sv
module sram_lane_gate (
    input  logic strobe_phase,
    input  logic lane_sel,
    output logic wr_n_next
);
    // A lane strobe goes low only in the strobe phase and only for a selected byte.
    assign wr_n_next = ~(strobe_phase & lane_sel);
endmodule

// File: rtl/sram_turn_guard.sv
module sram_turn_guard (
    input  logic have_last,
    input  logic last_write,
    input  logic next_write,
    output logic need_turn
);
    // A bus turnaround is needed only when the direction flips after some access.
    assign need_turn = have_last & (last_write ^ next_write);
endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W     = 13,
    parameter int DATA_W     = 16,
    parameter int LANE_W     = 8,
    parameter int SETUP_CYC  = 1,
    parameter int STROBE_CYC = 2,
    parameter int HOLD_CYC   = 1,
    parameter int ACC_CYC    = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic                     req_write,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [DATA_W-1:0]        req_wdata,
    input  logic [DATA_W/LANE_W-1:0] req_mask,
    output logic                     ack,
    output logic [DATA_W-1:0]        rdata,
    output logic [ADDR_W-1:0]        mem_addr,
    output logic                     mem_cs_n,
    output logic                     mem_oe_n,
    output logic [DATA_W/LANE_W-1:0] mem_wr_n,
    output logic [DATA_W-1:0]        mem_dq_o,
    output logic                     mem_dq_oe,
    input  logic [DATA_W-1:0]        mem_dq_i
);

    localparam int LANES  = DATA_W / LANE_W;
    localparam int MAXC   = max4(SETUP_CYC, STROBE_CYC, HOLD_CYC, ACC_CYC);
    localparam int CNT_W  = (MAXC > 1) ? $clog2(MAXC) : 1;

    localparam logic [CNT_W-1:0] SETUP_LD  = CNT_W'(SETUP_CYC - 1);
    localparam logic [CNT_W-1:0] STROBE_LD = CNT_W'(STROBE_CYC - 1);
    localparam logic [CNT_W-1:0] HOLD_LD   = CNT_W'(HOLD_CYC - 1);
    localparam logic [CNT_W-1:0] ACC_LD    = CNT_W'(ACC_CYC - 1);

    typedef struct packed {
        phase_e             phase;
        logic [CNT_W-1:0]   cnt;
        logic               write;
        logic [ADDR_W-1:0]  addr;
        logic [DATA_W-1:0]  wdata;
        logic [LANES-1:0]   mask;
        logic               have_last;
        logic               last_write;
        logic               cs_n;
        logic               oe_n;
        logic               dq_oe;
        logic               ack;
        logic [DATA_W-1:0]  rdata;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = '{
        phase:      PH_IDLE,
        cnt:        '0,
        write:      1'b0,
        addr:       '0,
        wdata:      '0,
        mask:       '0,
        have_last:  1'b0,
        last_write: 1'b0,
        cs_n:       1'b1,
        oe_n:       1'b1,
        dq_oe:      1'b0,
        ack:        1'b0,
        rdata:      '0
    };

    ctrl_t             ctrl_d, ctrl_q;
    logic [LANES-1:0]  wr_n_d, wr_n_q;
    logic              need_turn;
    logic              strobe_next;
    logic              cnt_done;

    sram_turn_guard u_turn (
        .have_last  (ctrl_q.have_last),
        .last_write (ctrl_q.last_write),
        .next_write (req_write),
        .need_turn  (need_turn)
    );

    assign cnt_done = (ctrl_q.cnt == '0);

    always_comb begin
        ctrl_d     = ctrl_q;
        ctrl_d.ack = 1'b0;
        case (ctrl_q.phase)
            PH_IDLE: begin
                if (req_valid && !ctrl_q.ack) begin
                    ctrl_d.write      = req_write;
                    ctrl_d.addr       = req_addr;
                    ctrl_d.wdata      = req_wdata;
                    ctrl_d.mask       = req_write ? req_mask : '0;
                    ctrl_d.have_last  = 1'b1;
                    ctrl_d.last_write = req_write;
                    if (need_turn) begin
                        ctrl_d.phase = PH_TURN;
                        ctrl_d.cnt   = '0;
                    end else if (req_write) begin
                        ctrl_d.phase = PH_SETUP;
                        ctrl_d.cnt   = SETUP_LD;
                    end else begin
                        ctrl_d.phase = PH_ACCESS;
                        ctrl_d.cnt   = ACC_LD;
                    end
                end
            end
            PH_TURN: begin
                if (ctrl_q.write) begin
                    ctrl_d.phase = PH_SETUP;
                    ctrl_d.cnt   = SETUP_LD;
                end else begin
                    ctrl_d.phase = PH_ACCESS;
                    ctrl_d.cnt   = ACC_LD;
                end
            end
            PH_SETUP: begin
                if (cnt_done) begin
                    ctrl_d.phase = PH_STROBE;
                    ctrl_d.cnt   = STROBE_LD;
                end else begin
                    ctrl_d.cnt = ctrl_q.cnt - 1'b1;
                end
            end
            PH_STROBE: begin
                if (cnt_done) begin
                    ctrl_d.phase = PH_HOLD;
                    ctrl_d.cnt   = HOLD_LD;
                end else begin
                    ctrl_d.cnt = ctrl_q.cnt - 1'b1;
                end
            end
            PH_HOLD: begin
                if (cnt_done) begin
                    ctrl_d.phase = PH_IDLE;
                    ctrl_d.ack   = 1'b1;
                end else begin
                    ctrl_d.cnt = ctrl_q.cnt - 1'b1;
                end
            end
            PH_ACCESS: begin
                if (cnt_done) begin
                    ctrl_d.phase = PH_IDLE;
                    ctrl_d.ack   = 1'b1;
                    ctrl_d.rdata = mem_dq_i;
                end else begin
                    ctrl_d.cnt = ctrl_q.cnt - 1'b1;
                end
            end
            default: ctrl_d.phase = PH_IDLE;
        endcase

        ctrl_d.cs_n  = !(ctrl_d.phase inside {PH_SETUP, PH_STROBE, PH_HOLD, PH_ACCESS});
        ctrl_d.oe_n  = (ctrl_d.phase != PH_ACCESS);
        ctrl_d.dq_oe = (ctrl_d.phase inside {PH_SETUP, PH_STROBE, PH_HOLD});
    end

    assign strobe_next = (ctrl_d.phase == PH_STROBE);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        sram_lane_gate u_gate (
            .strobe_phase (strobe_next),
            .lane_sel     (ctrl_d.mask[g]),
            .wr_n_next    (wr_n_d[g])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RST;
            wr_n_q <= '1;
        end else begin
            ctrl_q <= ctrl_d;
            wr_n_q <= wr_n_d;
        end
    end

    assign ack       = ctrl_q.ack;
    assign rdata     = ctrl_q.rdata;
    assign mem_addr  = ctrl_q.addr;
    assign mem_cs_n  = ctrl_q.cs_n;
    assign mem_oe_n  = ctrl_q.oe_n;
    assign mem_wr_n  = wr_n_q;
    assign mem_dq_o  = ctrl_q.wdata;
    assign mem_dq_oe = ctrl_q.dq_oe;

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_cs_n |-> ((&mem_wr_n) && mem_oe_n && !mem_dq_oe));

    // R5
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(&mem_wr_n) |-> (mem_oe_n && mem_dq_oe && !mem_cs_n));

    // R5
    drive_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (mem_oe_n && !mem_cs_n));

    // R2
    strobe_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(&mem_wr_n) |-> ($stable(mem_addr) && $stable(mem_dq_o) && $past(!mem_cs_n)));

    // R2
    strobe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(&mem_wr_n) |-> (!mem_cs_n && $stable(mem_addr) && $stable(mem_dq_o)));

    // R4
    read_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (!mem_cs_n && (&mem_wr_n) && !mem_dq_oe));

    // R6
    rd_after_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_oe_n) |-> ($past(mem_cs_n) && $past(!mem_dq_oe, 2)));

    // R6
    drive_after_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dq_oe) |-> ($past(mem_cs_n) && $past(mem_oe_n, 2)));

    // R7
    ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);

    // R7
    ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> (mem_cs_n && $past(!mem_cs_n)));

endmodule

// File: tb/test_sram_seq_ctrl.sv
module test_sram_seq_ctrl;

    localparam int SETUP_CYC  = 1;
    localparam int STROBE_CYC = 2;
    localparam int HOLD_CYC   = 1;
    localparam int ACC_CYC    = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [12:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_mask = '0;
    logic        ack;
    logic [15:0] rdata;
    logic [12:0] mem_addr;
    logic        mem_cs_n, mem_oe_n, mem_dq_oe;
    logic [1:0]  mem_wr_n;
    logic [15:0] mem_dq_o;
    logic [15:0] mem_dq_i = 16'hBAD0;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;
    bit have_last = 1'b0;
    bit last_write = 1'b0;
    int strobe_undriven = 0;

    logic [15:0] ram_model [int];
    logic [15:0] ref_mem   [int];

    always #5 clk = ~clk;

    sram_seq_ctrl #(
        .SETUP_CYC(SETUP_CYC), .STROBE_CYC(STROBE_CYC),
        .HOLD_CYC(HOLD_CYC), .ACC_CYC(ACC_CYC)
    ) i_sram_seq_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
        .ack(ack), .rdata(rdata), .mem_addr(mem_addr), .mem_cs_n(mem_cs_n),
        .mem_oe_n(mem_oe_n), .mem_wr_n(mem_wr_n), .mem_dq_o(mem_dq_o),
        .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
    );

    function automatic logic [15:0] model_rd(input int a);
        return ram_model.exists(a) ? ram_model[a] : 16'h0000;
    endfunction

    function automatic logic [15:0] ref_rd(input int a);
        return ref_mem.exists(a) ? ref_mem[a] : 16'h0000;
    endfunction

    function automatic logic [15:0] merge(input logic [15:0] old, input logic [15:0] nw,
                                          input logic [1:0] m);
        return {m[1] ? nw[15:8] : old[15:8], m[0] ? nw[7:0] : old[7:0]};
    endfunction

    // External asynchronous RAM, evaluated once per cycle while pins are steady
    always @(negedge clk) begin
        if (!mem_cs_n) begin
            logic [15:0] cur;
            cur = model_rd(int'(mem_addr));
            if (!mem_wr_n[0]) cur[7:0]  = mem_dq_o[7:0];
            if (!mem_wr_n[1]) cur[15:8] = mem_dq_o[15:8];
            if (mem_wr_n != 2'b11) begin
                ram_model[int'(mem_addr)] = cur;
                if (!mem_dq_oe) strobe_undriven++;
            end
        end
        mem_dq_i = (!mem_cs_n && !mem_oe_n) ? model_rd(int'(mem_addr)) : 16'hBAD0;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int turn_cost(input bit wr);
        return (have_last && (last_write != wr)) ? 1 : 0;
    endfunction

    task automatic do_write(input logic [12:0] a, input logic [15:0] d,
                            input logic [1:0] m);
        int cyc = 0, setup = 0, strobe = 0, hold = 0, bad = 0;
        logic [1:0] pat = 2'b11;
        int exp_lat;
        exp_lat = turn_cost(1'b1) + SETUP_CYC + STROBE_CYC + HOLD_CYC + 1;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d; req_mask = m;
        forever begin
            @(posedge clk); cyc++;
            @(negedge clk);
            if (ack || cyc > 200) break;
            if (!mem_cs_n) begin
                if (mem_addr != a || mem_dq_o != d || !mem_dq_oe || !mem_oe_n) bad++;
                if (mem_wr_n == 2'b11) begin
                    if (strobe == 0) setup++; else hold++;
                end else begin
                    strobe++; pat = mem_wr_n;
                end
            end
        end
        req_valid = 1'b0;
        ref_mem[int'(a)] = merge(ref_rd(int'(a)), d, m);
        chk(cyc == exp_lat, "R7 write ack latency", cyc, exp_lat);
        chk(bad == 0, "R2 addr/data held and driven during write", bad, 0);
        if (m != 2'b00) begin
            chk(setup == SETUP_CYC, "R2 setup cycles", setup, SETUP_CYC);
            chk(strobe == STROBE_CYC, "R2 strobe cycles", strobe, STROBE_CYC);
            chk(hold == HOLD_CYC, "R2 hold cycles", hold, HOLD_CYC);
            chk(pat == ~m, "R3 strobe lanes follow mask", pat, ~m);
        end else begin
            chk(strobe == 0, "R3 empty mask lowers no strobe", strobe, 0);
        end
        have_last = 1'b1; last_write = 1'b1;
    endtask

    task automatic do_read(input logic [12:0] a, input bit linger);
        int cyc = 0, oe_cyc = 0;
        int exp_lat;
        logic [15:0] got, exp;
        exp_lat = turn_cost(1'b0) + ACC_CYC + 1;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_wdata = 16'h0; req_mask = 2'b11;
        forever begin
            @(posedge clk); cyc++;
            @(negedge clk);
            if (ack || cyc > 200) break;
            if (!mem_oe_n) oe_cyc++;
        end
        got = rdata;
        exp = ref_rd(int'(a));
        if (linger) begin
            // R8: request still asserted through the acknowledge cycle
            @(negedge clk);
            req_valid = 1'b0;
            for (int k = 0; k < 3; k++) begin
                chk(mem_cs_n && !ack, "R8 no second access from held request",
                    {mem_cs_n, ack}, 2'b10);
                @(negedge clk);
            end
        end
        req_valid = 1'b0;
        chk(cyc == exp_lat, "R7 read ack latency", cyc, exp_lat);
        chk(oe_cyc == ACC_CYC, "R4 output enable cycles", oe_cyc, ACC_CYC);
        chk(got == exp, "R4 read data", got, exp);
        have_last = 1'b1; last_write = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (5) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk(mem_cs_n && mem_oe_n && mem_wr_n == 2'b11 && !mem_dq_oe && !ack,
            "R1 reset pins", {mem_cs_n, mem_oe_n, mem_wr_n, mem_dq_oe, ack}, 6'b111100);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(mem_cs_n && mem_oe_n && mem_wr_n == 2'b11 && !mem_dq_oe && !ack,
            "R1 idle pins after reset", {mem_cs_n, mem_oe_n, mem_wr_n, mem_dq_oe, ack}, 6'b111100);

        // Directed corners
        do_write(13'h0000, 16'hA55A, 2'b11);   // first access, no turnaround (R6)
        do_write(13'h1FFF, 16'h1234, 2'b11);   // same direction
        do_write(13'h1FFF, 16'hFFEE, 2'b01);   // low byte only (R3)
        do_write(13'h1FFF, 16'h77CC, 2'b10);   // high byte only (R3)
        do_write(13'h1FFF, 16'h9999, 2'b00);   // empty mask (R3)
        do_read(13'h1FFF, 1'b0);               // write->read turnaround (R6)
        do_read(13'h0000, 1'b1);               // read->read, held request (R8)
        do_write(13'h0000, 16'h0F0F, 2'b10);   // read->write turnaround (R6)
        do_read(13'h0000, 1'b0);
        do_read(13'h0123, 1'b0);               // never written
        repeat (2) @(negedge clk);
        chk(mem_cs_n && !mem_dq_oe, "R1 standby between requests", {mem_cs_n, mem_dq_oe}, 2'b10);

        // Random mix over a small address pool
        for (int i = 0; i < 300; i++) begin
            logic [12:0] a;
            int sel;
            sel = int'($urandom % 8);
            a = (sel == 0) ? 13'h0000 : (sel == 1) ? 13'h1FFF : 13'(($urandom % 6) * 13'h155);
            if ($urandom % 2) do_write(a, 16'($urandom), 2'($urandom));
            else do_read(a, 1'b0);
            repeat ($urandom % 3) @(negedge clk);
        end

        chk(strobe_undriven == 0, "R5 strobe low only while bus driven", strobe_undriven, 0);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule